// File: doc/BRIEF.md
# Command-driven up/down timer/counter

This block is a single timer/counter that advances once per prescaled tick enable and wraps against a programmable period. Software steers it through one control byte, which it reaches through two write strobes on the same data bus. A write with the set strobe raises single-bit controls and loads a pending command code. A write with the clear strobe lowers single-bit controls. The byte can be read back at all times.

A pending command is not acted on at the moment it is written. It waits for the next tick and runs on that tick, and the command field then reads zero again. The commands are restart, halt, forced buffer update, count read synchronization and a one-shot DMA request. The block produces the count, wrap events and single-clock strobes. A separate block consumes the update strobe and performs the copy of the double-buffered registers. The hardware update made on a wrap can be held off with a lock control. A one-shot control stops the counter after its next wrap.

Top module: `cmdtimer_top`

## Requirements
- R1: After reset, ctrl_rd is 0x00 and count is 0. The counter is halted and every pulse output is low.
- R2: A set write with bit 2 at 1 turns on one-shot, bit 1 at 1 turns on update lock, and bit 0 at 1 selects down-counting (0 means up-counting). Bits written as 0 change nothing. Bits 4:3 are reserved: they read 0 and writes to them are ignored.
- R3: A clear write with a 1 in bit 2, 1 or 0 turns the matching control off. Bits written as 0 change nothing, and a clear write never alters the command field.
- R4: A set write whose bits 7:5 hold 1 (restart), 2 (halt), 3 (update), 4 (read sync) or 5 (DMA) stores that code as the pending command, which reads back in ctrl_rd[7:5] and replaces any earlier pending code. The codes 0, 6 and 7 leave the pending command unchanged.
- R5: A pending command runs on the next clock with tick high. After that edge, ctrl_rd[7:5] reads 0.
- R6: Restart loads 0 when counting up, or loads period when counting down, and sets running to 1.
- R7: Halt clears running. A halted counter holds its count until a restart runs.
- R8: On each tick while the counter is running and counting up, the count increments. A tick when count is at or above period sets count to 0 and pulses ovf_pulse.
- R9: On each tick while the counter is running and counting down, the count decrements. A tick when count is 0 loads period and pulses unf_pulse.
- R10: With one-shot on, a wrap also clears running, so the count stays at its wrapped value.
- R11: upd_req pulses on the tick that runs an update command. It also pulses on every wrap while update lock is off, and it stays low on a wrap while update lock is on.
- R12: rsync_done and dma_trig each go high for exactly one clock, in the clock after the tick that runs the read-sync command or the DMA command.
- R13: Without a tick, count, running and all pulse outputs hold or stay low, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| period | input | CNT_W | Wrap value of the counter |
| wr_set | input | 1 | Set-style write strobe |
| wr_clr | input | 1 | Clear-style write strobe |
| wr_data | input | 8 | Control byte written by either strobe |
| ctrl_rd | output | 8 | Control byte read back: command, reserved, one-shot, lock, direction |
| count | output | CNT_W | Current count |
| running | output | 1 | Counter is running |
| ovf_pulse | output | 1 | Up-count wrap event |
| unf_pulse | output | 1 | Down-count wrap event |
| upd_req | output | 1 | Request to copy buffered registers |
| rsync_done | output | 1 | Read synchronization completed |
| dma_trig | output | 1 | One-shot DMA request |

## Verification
The hardest case to reach from the ports is the overlap of a command and a wrap on the same tick. Examples are a forced update while update lock holds back the wrap update, and one-shot stopping on exactly the tick that wraps. The bench reaches these cases in two steps. It first sweeps every period from 0 to 7 in both directions, and predicts each count and wrap arithmetically for each tick. It then places specific commands a known number of ticks after a restart, so that each one lands on a predicted count.

// File: rtl/cmdtimer_pkg.sv
package cmdtimer_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_RESTART   = 3'd1,
        CMD_HALT      = 3'd2,
        CMD_FORCE_UPD = 3'd3,
        CMD_RSYNC     = 3'd4,
        CMD_DMA       = 3'd5
    } cmd_e;

    localparam int CTRL_W    = 8;
    localparam int CMD_LSB   = 5;
    localparam int BIT_ONESH = 2;
    localparam int BIT_LOCK  = 1;
    localparam int BIT_DOWN  = 0;

    typedef struct packed {
        logic oneshot;
        logic lock;
        logic down;
    } flags_t;

    function automatic logic cmd_is_valid(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

endpackage

// File: rtl/cmdtimer_regs.sv
module cmdtimer_regs
    import cmdtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [CTRL_W-1:0] wr_data,
    output flags_t            flags,
    output cmd_e              pend_cmd
);

    typedef struct packed {
        cmd_e   cmd;
        flags_t fl;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_rsvd;

    assign unused_rsvd = ^wr_data[4:3];

    always_comb begin
        r_d = r_q;
        // the pending command is consumed by the tick that runs it
        if (tick) begin
            r_d.cmd = CMD_NONE;
        end
        if (wr_clr) begin
            if (wr_data[BIT_ONESH]) r_d.fl.oneshot = 1'b0;
            if (wr_data[BIT_LOCK])  r_d.fl.lock    = 1'b0;
            if (wr_data[BIT_DOWN])  r_d.fl.down    = 1'b0;
        end
        // set applied after clear: set wins when both strobes coincide
        if (wr_set) begin
            if (wr_data[BIT_ONESH]) r_d.fl.oneshot = 1'b1;
            if (wr_data[BIT_LOCK])  r_d.fl.lock    = 1'b1;
            if (wr_data[BIT_DOWN])  r_d.fl.down    = 1'b1;
            if (cmd_is_valid(wr_data[CTRL_W-1:CMD_LSB])) begin
                r_d.cmd = cmd_e'(wr_data[CTRL_W-1:CMD_LSB]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{cmd: CMD_NONE, fl: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign flags    = r_q.fl;
    assign pend_cmd = r_q.cmd;

endmodule

// File: rtl/cmdtimer_count.sv
module cmdtimer_count
    import cmdtimer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cmd_e             cmd,
    input  flags_t           flags,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             ovf,
    output logic             unf,
    output logic             upd,
    output logic             rsync,
    output logic             dma
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             ovf;
        logic             unf;
        logic             upd;
        logic             rsync;
        logic             dma;
    } state_t;

    state_t s_d, s_q;
    logic   wrap;

    always_comb begin
        s_d       = s_q;
        s_d.ovf   = 1'b0;
        s_d.unf   = 1'b0;
        s_d.upd   = 1'b0;
        s_d.rsync = 1'b0;
        s_d.dma   = 1'b0;
        wrap      = 1'b0;
        if (tick) begin
            case (cmd)
                CMD_RESTART: begin
                    s_d.cnt = flags.down ? period : CNT_ZERO;
                    s_d.run = 1'b1;
                end
                CMD_HALT: begin
                    s_d.run = 1'b0;
                end
                default: begin
                    s_d.upd   = (cmd == CMD_FORCE_UPD);
                    s_d.rsync = (cmd == CMD_RSYNC);
                    s_d.dma   = (cmd == CMD_DMA);
                    if (s_q.run) begin
                        if (!flags.down) begin
                            if (s_q.cnt >= period) begin
                                s_d.cnt = CNT_ZERO;
                                s_d.ovf = 1'b1;
                                wrap    = 1'b1;
                            end else begin
                                s_d.cnt = s_q.cnt + CNT_ONE;
                            end
                        end else begin
                            if (s_q.cnt == CNT_ZERO) begin
                                s_d.cnt = period;
                                s_d.unf = 1'b1;
                                wrap    = 1'b1;
                            end else begin
                                s_d.cnt = s_q.cnt - CNT_ONE;
                            end
                        end
                        if (wrap) begin
                            if (flags.oneshot) s_d.run = 1'b0;
                            if (!flags.lock)   s_d.upd = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign running = s_q.run;
    assign ovf     = s_q.ovf;
    assign unf     = s_q.unf;
    assign upd     = s_q.upd;
    assign rsync   = s_q.rsync;
    assign dma     = s_q.dma;

endmodule

// File: rtl/cmdtimer_top.sv
module cmdtimer_top
    import cmdtimer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       ctrl_rd,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             ovf_pulse,
    output logic             unf_pulse,
    output logic             upd_req,
    output logic             rsync_done,
    output logic             dma_trig
);

    flags_t flags;
    cmd_e   pend_cmd;

    cmdtimer_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .wr_data  (wr_data),
        .flags    (flags),
        .pend_cmd (pend_cmd)
    );

    cmdtimer_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmd     (pend_cmd),
        .flags   (flags),
        .period  (period),
        .count   (count),
        .running (running),
        .ovf     (ovf_pulse),
        .unf     (unf_pulse),
        .upd     (upd_req),
        .rsync   (rsync_done),
        .dma     (dma_trig)
    );

    assign ctrl_rd = {pend_cmd, 2'b00, flags.oneshot, flags.lock, flags.down};

endmodule

// File: rtl/cmdtimer_chk.sv
module cmdtimer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] period,
    input logic             wr_set,
    input logic [7:0]       wr_data,
    input logic [7:0]       ctrl_rd,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             ovf_pulse,
    input logic             unf_pulse,
    input logic             upd_req,
    input logic             rsync_done,
    input logic             dma_trig
);

    // R4
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !tick && (wr_data[7:5] == 3'd0 || wr_data[7:5] > 3'd5))
        |=> $stable(ctrl_rd[7:5]));

    // R5
    cmd_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_set) |=> (ctrl_rd[7:5] == 3'd0));

    // R7
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(tick && ctrl_rd[7:5] == 3'd1)) |=> $stable(count));

    // R8
    ovf_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));

    // R9
    unf_to_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_pulse |-> (count == $past(period)));

    // R13
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(count) && $stable(running)));

    // R13
    no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !(ovf_pulse || unf_pulse || upd_req || rsync_done || dma_trig));

    // R12
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsync_done, dma_trig, ovf_pulse && unf_pulse}) <= 1);

endmodule

bind cmdtimer_top cmdtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .period     (period),
    .wr_set     (wr_set),
    .wr_data    (wr_data),
    .ctrl_rd    (ctrl_rd),
    .count      (count),
    .running    (running),
    .ovf_pulse  (ovf_pulse),
    .unf_pulse  (unf_pulse),
    .upd_req    (upd_req),
    .rsync_done (rsync_done),
    .dma_trig   (dma_trig)
);

// File: tb/cmdtimer_top_bench.sv
module cmdtimer_top_bench;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] period = '0;
    logic             wr_set = 1'b0;
    logic             wr_clr = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       ctrl_rd;
    logic [CNT_W-1:0] count;
    logic             running, ovf_pulse, unf_pulse, upd_req, rsync_done, dma_trig;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmdtimer_top #(.CNT_W(CNT_W)) u_cmdtimer_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
        .wr_set(wr_set), .wr_clr(wr_clr), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .count(count), .running(running),
        .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse), .upd_req(upd_req),
        .rsync_done(rsync_done), .dma_trig(dma_trig)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit set, input logic [7:0] d);
        @(negedge clk);
        wr_set = set; wr_clr = !set; wr_data = d;
        @(negedge clk);
        wr_set = 1'b0; wr_clr = 1'b0; wr_data = '0;
    endtask

    task automatic tk();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic restart();
        wr(1'b1, 8'h20);
        tk();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int held;
        int pend;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_rd, 0);
        chk("R1 count", count, 0);
        chk("R1 running", running, 0);
        chk("R1 pulses", {ovf_pulse, unf_pulse, upd_req, rsync_done, dma_trig}, 0);

        // R8 R9 R6: sweep of period and direction
        for (int dn = 0; dn < 2; dn++) begin
            wr(dn == 1, 8'h01);
            for (int p = 0; p < 8; p++) begin
                period = CNT_W'(p);
                restart();
                chk("R6 load", count, dn ? p : 0);
                chk("R6 run", running, 1);
                for (int k = 1; k <= 2 * (p + 1) + 1; k++) begin
                    int ph;
                    ph = k % (p + 1);
                    tk();
                    if (dn == 0) begin
                        chk("R8 count", count, ph);
                        chk("R8 ovf", ovf_pulse, ph == 0);
                    end else begin
                        chk("R9 count", count, p - ph);
                        chk("R9 unf", unf_pulse, ph == 0);
                    end
                    chk("R11 wrap upd", upd_req, ph == 0);
                end
            end
        end

        // R2 R3 control bits
        wr(1'b0, 8'h07); chk("R3 clear all", ctrl_rd, 8'h00);
        wr(1'b1, 8'h05); chk("R2 set", ctrl_rd, 8'h05);
        wr(1'b1, 8'h18); chk("R2 reserved", ctrl_rd, 8'h05);
        wr(1'b1, 8'h00); chk("R2 zero write", ctrl_rd, 8'h05);
        wr(1'b0, 8'h04); chk("R3 clear one", ctrl_rd, 8'h01);
        wr(1'b0, 8'h00); chk("R3 zero write", ctrl_rd, 8'h01);
        wr(1'b0, 8'h01); chk("R3 clear dir", ctrl_rd, 8'h00);

        // R4 command codes, replacement; R13 no effect without tick
        period = 8'd20;
        restart();
        tk();
        held = count;
        wr(1'b1, 8'h40);
        pend = 2;
        for (int c = 0; c < 8; c++) begin
            wr(1'b1, 8'(c << 5));
            if (c >= 1 && c <= 5) pend = c;
            chk("R4 pending", ctrl_rd[7:5], pend);
        end
        wr(1'b0, 8'hE0);
        chk("R3 clear keeps cmd", ctrl_rd[7:5], pend);
        chk("R13 count held", count, held);
        chk("R13 quiet", {ovf_pulse, unf_pulse, upd_req, rsync_done, dma_trig}, 0);
        tk();
        chk("R12 dma", dma_trig, 1);
        chk("R5 cleared", ctrl_rd[7:5], 0);
        @(negedge clk);
        chk("R12 dma single", dma_trig, 0);

        // R7 halt
        period = 8'd9;
        restart();
        repeat (3) tk();
        chk("R8 pre-halt", count, 3);
        wr(1'b1, 8'h40);
        tk();
        chk("R7 halted", running, 0);
        chk("R7 count", count, 3);
        repeat (2) tk();
        chk("R7 holds", count, 3);

        // R10 one-shot stops at wrap
        wr(1'b1, 8'h04);
        period = 8'd2;
        restart();
        tk(); tk(); tk();
        chk("R10 wrap", ovf_pulse, 1);
        chk("R10 count", count, 0);
        chk("R10 stopped", running, 0);
        tk();
        chk("R10 stays", count, 0);
        chk("R10 no ovf", ovf_pulse, 0);
        restart();
        tk();
        wr(1'b1, 8'h40);
        tk();
        chk("R7 oneshot halt", running, 0);
        wr(1'b0, 8'h04);

        // R11 update lock and forced update
        wr(1'b1, 8'h02);
        period = 8'd1;
        restart();
        tk();
        tk();
        chk("R11 locked ovf", ovf_pulse, 1);
        chk("R11 locked upd", upd_req, 0);
        wr(1'b1, 8'h60);
        tk();
        chk("R11 forced upd", upd_req, 1);
        chk("R11 count on", count, 1);
        wr(1'b0, 8'h02);
        tk();
        chk("R11 unlocked ovf", ovf_pulse, 1);
        chk("R11 unlocked upd", upd_req, 1);

        // R12 read sync
        wr(1'b1, 8'h80);
        chk("R12 no early rsync", rsync_done, 0);
        tk();
        chk("R12 rsync", rsync_done, 1);
        chk("R5 rsync cleared", ctrl_rd[7:5], 0);
        @(negedge clk);
        chk("R12 rsync single", rsync_done, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule